// File: doc/BRIEF.md
# Microsecond Slot Timer with Offset Event

This block keeps time in fixed-length slots counted in microseconds. A fine counter advances once per 1 us tick and returns to zero after reaching a programmable window value, so a slot lasts window + 1 microseconds. Each return to zero advances a 32-bit slot counter. Software reads both counters directly from the output ports.

Inside each slot, a programmable offset marks the point where a slot event is raised. The event sets a sticky slot flag. If a new event arrives while that flag is still set, a sticky overrun flag is raised. A single clear input drops both flags. Each flag has its own enable into one registered interrupt line.

A hold input freezes counting. A one-cycle load strobe copies the two preset inputs into the live counters and overrides both counting and hold in that cycle. Software normally programs the window to 999, which gives a 1 ms slot. The window and offset fields are 12 bits wide, so the longest slot is 4096 us.

Top module: `slot_timer`

## Requirements
- R1: A synchronous active-high reset sets both counters, both flags and the interrupt to 0 at the next clock edge.
- R2: On a clock edge where tick is 1 and hold and load are 0, the fine count goes up by one. If the fine count is already equal to or above the window, it goes to 0 instead and the slot count goes up by one.
- R3: The slot count is 32 bits wide. When it wraps, it goes from all ones to 0.
- R4: While hold is 1 and load is 0, both counters keep their values and no slot event occurs, whatever the tick input does.
- R5: When load is 1, the fine and slot presets are copied into the counters at that edge. This happens regardless of tick and hold, and no slot event occurs in that cycle.
- R6: A slot event occurs on a counting edge whose resulting fine count equals the offset. A wrap to 0 counts when the offset is 0. An offset above the window never produces an event. An event sets the slot flag.
- R7: When an event occurs while the slot flag is already 1 and clear is 0, the overrun flag is set to 1.
- R8: Clear drops both flags to 0 at the next edge. If an event happens in the same cycle as clear, the slot flag ends at 1 and the overrun flag ends at 0.
- R9: The interrupt output equals (slot flag AND slot enable) OR (overrun flag AND overrun enable). It uses the flag values and enables from the same edge, so the interrupt changes on the same edge as the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| hold | input | 1 | Freeze counting |
| load | input | 1 | One-cycle strobe: copy presets into counters |
| fine_preset | input | FINE_W | Value loaded into fine counter |
| slot_preset | input | SLOT_W | Value loaded into slot counter |
| window | input | FINE_W | Last fine count of a slot (slot = window+1 us) |
| offset | input | FINE_W | Fine count at which the slot event fires |
| flag_clr | input | 1 | Clear slot and overrun flags |
| ie_slot | input | 1 | Interrupt enable for the slot flag |
| ie_over | input | 1 | Interrupt enable for the overrun flag |
| fine_cnt | output | FINE_W | Live fine count |
| slot_cnt | output | SLOT_W | Live slot count |
| slot_flag | output | 1 | Sticky slot-event flag |
| over_flag | output | 1 | Sticky overrun flag |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the block with its default parameters: 12-bit fine fields and a 32-bit slot counter. It programs small windows of three microseconds at run time, so many wraps, events and overruns fit into a few dozen cycles. The 32-bit wrap is reached by loading an all-ones slot preset rather than by counting. Offsets of zero and offsets above the window are set at run time to cover the boundary event placements.

// File: rtl/slot_timer_pkg.sv
package slot_timer_pkg;
  // Action the fine counter takes at the coming clock edge
  typedef enum logic [1:0] {
    FA_IDLE = 2'd0,
    FA_LOAD = 2'd1,
    FA_STEP = 2'd2,
    FA_WRAP = 2'd3
  } fine_act_e;
endpackage

// File: rtl/slot_timer_fine.sv
module slot_timer_fine
  import slot_timer_pkg::*;
#(
  parameter int FW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_us,
  input  logic          hold,
  input  logic          load,
  input  logic [FW-1:0] window,
  input  logic [FW-1:0] preset,
  output logic [FW-1:0] cnt,
  output fine_act_e     act
);
  localparam logic [FW-1:0] ONE = {{(FW-1){1'b0}}, 1'b1};

  always_comb begin
    if (load)                 act = FA_LOAD;
    else if (hold || !tick_us) act = FA_IDLE;
    else if (cnt >= window)   act = FA_WRAP;
    else                      act = FA_STEP;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else begin
      case (act)
        FA_LOAD: cnt <= preset;
        FA_STEP: cnt <= cnt + ONE;
        FA_WRAP: cnt <= '0;
        default: cnt <= cnt;
      endcase
    end
  end

  a_r2_fine_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick_us && !hold && !load && cnt >= window) |=> (cnt == '0));
  a_r4_hold_freeze: assert property (@(posedge clk) disable iff (rst)
    (hold && !load) |=> $stable(cnt));
  a_r5_load_fine: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(preset)));
endmodule

// File: rtl/slot_timer_slot.sv
module slot_timer_slot
  import slot_timer_pkg::*;
#(
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  fine_act_e     act,
  input  logic [SW-1:0] preset,
  output logic [SW-1:0] cnt
);
  localparam logic [SW-1:0] ONE = {{(SW-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (act == FA_LOAD) cnt <= preset;
    else if (act == FA_WRAP) cnt <= cnt + ONE;
  end

  a_r2_slot_step: assert property (@(posedge clk) disable iff (rst)
    (act == FA_WRAP) |=> (cnt == $past(cnt) + ONE));
  a_r3_slot_rollover: assert property (@(posedge clk) disable iff (rst)
    (act == FA_WRAP && cnt == '1) |=> (cnt == '0));
  a_r5_load_slot: assert property (@(posedge clk) disable iff (rst)
    (act == FA_LOAD) |=> (cnt == $past(preset)));
endmodule

// File: rtl/slot_timer_flags.sv
module slot_timer_flags
  import slot_timer_pkg::*;
#(
  parameter int FW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  fine_act_e     act,
  input  logic [FW-1:0] fine_cnt,
  input  logic [FW-1:0] offset,
  input  logic          flag_clr,
  input  logic          ie_slot,
  input  logic          ie_over,
  output logic          slot_flag,
  output logic          over_flag,
  output logic          irq
);
  localparam logic [FW-1:0] ONE = {{(FW-1){1'b0}}, 1'b1};

  logic ev;
  logic slot_n, over_n;

  always_comb begin
    ev = ((act == FA_STEP) && (fine_cnt + ONE == offset)) ||
         ((act == FA_WRAP) && (offset == '0));
    slot_n = (slot_flag && !flag_clr) || ev;
    over_n = (over_flag && !flag_clr) || (ev && slot_flag && !flag_clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_flag <= 1'b0;
      over_flag <= 1'b0;
      irq       <= 1'b0;
    end else begin
      slot_flag <= slot_n;
      over_flag <= over_n;
      irq       <= (slot_n && ie_slot) || (over_n && ie_over);
    end
  end

  a_r6_no_event_idle: assert property (@(posedge clk) disable iff (rst)
    (act != FA_STEP && act != FA_WRAP && !slot_flag) |=> !slot_flag);
  a_r7_overrun_set: assert property (@(posedge clk) disable iff (rst)
    (ev && slot_flag && !flag_clr) |=> over_flag);
  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !ev) |=> (!slot_flag && !over_flag));
  a_r8_clear_vs_event: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && ev) |=> (slot_flag && !over_flag));
  a_r9_irq_mask: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == ((slot_flag && $past(ie_slot)) || (over_flag && $past(ie_over)))));
endmodule

// File: rtl/slot_timer.sv
module slot_timer
  import slot_timer_pkg::*;
#(
  parameter int FINE_W = 12,
  parameter int SLOT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_us,
  input  logic              hold,
  input  logic              load,
  input  logic [FINE_W-1:0] fine_preset,
  input  logic [SLOT_W-1:0] slot_preset,
  input  logic [FINE_W-1:0] window,
  input  logic [FINE_W-1:0] offset,
  input  logic              flag_clr,
  input  logic              ie_slot,
  input  logic              ie_over,
  output logic [FINE_W-1:0] fine_cnt,
  output logic [SLOT_W-1:0] slot_cnt,
  output logic              slot_flag,
  output logic              over_flag,
  output logic              irq
);
  fine_act_e act;

  slot_timer_fine #(.FW(FINE_W)) u_fine (
    .clk(clk), .rst(rst), .tick_us(tick_us), .hold(hold), .load(load),
    .window(window), .preset(fine_preset), .cnt(fine_cnt), .act(act)
  );

  slot_timer_slot #(.SW(SLOT_W)) u_slot (
    .clk(clk), .rst(rst), .act(act), .preset(slot_preset), .cnt(slot_cnt)
  );

  slot_timer_flags #(.FW(FINE_W)) u_flags (
    .clk(clk), .rst(rst), .act(act), .fine_cnt(fine_cnt), .offset(offset),
    .flag_clr(flag_clr), .ie_slot(ie_slot), .ie_over(ie_over),
    .slot_flag(slot_flag), .over_flag(over_flag), .irq(irq)
  );

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (fine_cnt == '0 && slot_cnt == '0 && !slot_flag && !over_flag && !irq));
endmodule

// File: tb/sim_slot_timer.sv
module sim_slot_timer;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 12;
  localparam int SW = 32;

  logic clk = 1'b0;
  logic rst, tick_us, hold, load, flag_clr, ie_slot, ie_over;
  logic [FW-1:0] fine_preset, window, offset, fine_cnt;
  logic [SW-1:0] slot_preset, slot_cnt;
  logic slot_flag, over_flag, irq;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_timer #(.FINE_W(FW), .SLOT_W(SW)) u0 (
    .clk(clk), .rst(rst), .tick_us(tick_us), .hold(hold), .load(load),
    .fine_preset(fine_preset), .slot_preset(slot_preset), .window(window),
    .offset(offset), .flag_clr(flag_clr), .ie_slot(ie_slot), .ie_over(ie_over),
    .fine_cnt(fine_cnt), .slot_cnt(slot_cnt), .slot_flag(slot_flag),
    .over_flag(over_flag), .irq(irq)
  );

  typedef struct packed {
    logic        tk, hd, ld, cl;
    logic [11:0] fine;
    logic [31:0] slot;
    logic        f, o, i;
  } vec_t;

  // window 3, offset 2, both enables on
  localparam vec_t VEC [14] = '{
    '{1'b1,1'b0,1'b0,1'b0,12'd1,32'd0,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,12'd2,32'd0,1'b1,1'b0,1'b1},
    '{1'b1,1'b0,1'b0,1'b0,12'd3,32'd0,1'b1,1'b0,1'b1},
    '{1'b1,1'b0,1'b0,1'b0,12'd0,32'd1,1'b1,1'b0,1'b1},
    '{1'b1,1'b0,1'b0,1'b0,12'd1,32'd1,1'b1,1'b0,1'b1},
    '{1'b1,1'b0,1'b0,1'b0,12'd2,32'd1,1'b1,1'b1,1'b1},
    '{1'b0,1'b0,1'b0,1'b1,12'd2,32'd1,1'b0,1'b0,1'b0},
    '{1'b1,1'b1,1'b0,1'b0,12'd2,32'd1,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,12'd3,32'd1,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,12'd0,32'd2,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,12'd1,32'd2,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,1'b1,12'd2,32'd2,1'b1,1'b0,1'b1},
    '{1'b0,1'b0,1'b0,1'b0,12'd2,32'd2,1'b1,1'b0,1'b1},
    '{1'b1,1'b0,1'b0,1'b0,12'd3,32'd2,1'b1,1'b0,1'b1}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // apply inputs just after an edge, let one edge pass, sample mid-cycle
  task automatic step(input logic tk, input logic hd, input logic ld, input logic cl);
    tick_us = tk; hold = hd; load = ld; flag_clr = cl;
    @(posedge clk); #1;
    tick_us = 1'b0; hold = 1'b0; load = 1'b0; flag_clr = 1'b0;
  endtask

  function automatic logic [63:0] pack(input logic [11:0] f, input logic [31:0] s,
                                       input logic a, input logic b, input logic c);
    return {17'd0, f, s, a, b, c};
  endfunction

  initial begin
    #(CLK_PERIOD*100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; tick_us = 0; hold = 0; load = 0; flag_clr = 0;
    ie_slot = 1; ie_over = 1; fine_preset = '0; slot_preset = '0;
    window = 12'd3; offset = 12'd2;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 reset", pack(fine_cnt, slot_cnt, slot_flag, over_flag, irq), pack(0, 0, 0, 0, 0));
    rst = 1'b0;

    // table walk: R2 counting, R6 event, R7 overrun, R8 clear, R4 hold, R9 irq
    for (int k = 0; k < 14; k++) begin
      step(VEC[k].tk, VEC[k].hd, VEC[k].ld, VEC[k].cl);
      check($sformatf("R2/R4/R6/R7/R8/R9 vector %0d", k),
            pack(fine_cnt, slot_cnt, slot_flag, over_flag, irq),
            pack(VEC[k].fine, VEC[k].slot, VEC[k].f, VEC[k].o, VEC[k].i));
    end

    // R8: clear
    step(0, 0, 0, 1);
    check("R8 clear flags", {slot_flag, over_flag, irq}, 3'b000);

    // R5: load beats hold and tick, no event even though preset equals offset
    fine_preset = 12'd2; slot_preset = 32'hFFFF_FFFF;
    step(1, 1, 1, 0);
    check("R5 load fine", fine_cnt, 12'd2);
    check("R5 load slot", slot_cnt, 32'hFFFF_FFFF);
    check("R5 no event on load", slot_flag, 1'b0);

    // R3: slot counter rollover
    step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    check("R3 rollover fine", fine_cnt, 12'd0);
    check("R3 rollover slot", slot_cnt, 32'd0);

    // R6: offset above window never fires
    offset = 12'd7;
    for (int k = 0; k < 8; k++) step(1, 0, 0, 0);
    check("R6 offset beyond window", slot_flag, 1'b0);
    check("R2 two wraps", pack(fine_cnt, slot_cnt, 0, 0, 0), pack(0, 2, 0, 0, 0));

    // R6: offset 0 fires on the wrap
    offset = 12'd0;
    for (int k = 0; k < 3; k++) step(1, 0, 0, 0);
    check("R6 offset0 not before wrap", slot_flag, 1'b0);
    step(1, 0, 0, 0);
    check("R6 offset0 at wrap", {fine_cnt, slot_flag}, {12'd0, 1'b1});

    // R9: enables mask each flag
    ie_slot = 1'b0;
    step(0, 0, 0, 0);
    check("R9 slot masked", {slot_flag, irq}, 2'b10);
    for (int k = 0; k < 4; k++) step(1, 0, 0, 0);
    check("R7 overrun again", over_flag, 1'b1);
    check("R9 overrun enabled", irq, 1'b1);

    // R4: hold blocks event
    ie_slot = 1'b1;
    step(0, 0, 0, 1);
    offset = 12'd1;
    step(1, 1, 0, 0);
    check("R4 hold", {fine_cnt, slot_flag}, {12'd0, 1'b0});
    step(1, 0, 0, 0);
    check("R6 event after hold", {fine_cnt, slot_flag, irq}, {12'd1, 1'b1, 1'b1});

    // R1: reset mid-run
    rst = 1'b1;
    step(1, 0, 0, 0);
    rst = 1'b0;
    check("R1 reset midrun", pack(fine_cnt, slot_cnt, slot_flag, over_flag, irq), pack(0, 0, 0, 0, 0));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule